// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This block sits beside the sequencer of an 8/16-bit processor core and decides, when an exception entry starts, which source is being serviced. It keeps a register of pending hardware requests (power-on, reset, abort, non-maskable interrupt and maskable interrupt). It also presents, every cycle, the subset that the core would honour given the current interrupt-disable flag.

When the sequencer pulses `enter_i`, the unit picks the winning source. If no hardware request is honoured, the winner is the software interrupt named by `sw_cop_i`. For that source the unit latches the vector address, the stack frame image and its byte length, the new program bank and the new interrupt-disable flag, and it clears the serviced pending bit. The sequencer then pushes the frame and fetches the vector. Frame layout and vectors depend on the emulation bit `emu_i`.

Top module: `exc_vector_unit`

## Requirements
- R1: On entry the source is chosen in the fixed order reset (power-on or reset) > abort > NMI > IRQ > software. `src_o` reports it as 0 reset, 1 abort, 2 NMI, 3 IRQ, 4 BRK, 5 COP. A software source is BRK when `sw_cop_i`=0 and COP when it is 1.
- R2: Servicing a hardware source clears its pending bit at the entry edge. A reset entry clears both the power-on and reset bits. A software entry clears nothing. The bit encoding of `pending_o` and `honour_o` is bit0 power-on, bit1 reset, bit2 IRQ, bit3 NMI, bit4 abort.
- R3: An NMI is latched on a rising edge of `nmi_req_i`. A line held high after service does not pend again, and a new rising edge does.
- R4: The IRQ pending bit follows the `irq_req_i` level one cycle later, except that it reads 0 in the cycle after its own service.
- R5: Vectors are 0xFFFC for reset, 0xFFF8 for abort, 0xFFFA for NMI, 0xFFFE for IRQ, and 0xFFF4 for COP. BRK vectors to 0xFFFE in emulation and to 0xFFF6 in native mode.
- R6: In emulation mode (`emu_i`=1) the frame length is 3. `frame_o` is {0x00, PC[15:8], PC[7:0], flags}, and bytes are pushed from the high end down. The flags byte has bit 4 set for BRK and cleared for every other source.
- R7: In native mode the frame length is 4 and `frame_o` is {program bank, PC, flags unchanged}. `pbank_o` becomes 0x00. In emulation `pbank_o` equals `pbank_i`.
- R8: After any entry `idis_o` is 1.
- R9: `honour_o` equals `pending_o` with bit 2 forced to 0 while `idis_i`=1. The power-on, reset, abort and NMI bits are always passed.
- R10: `done_o` is 1 exactly in the cycle after an `enter_i` cycle. All latched results appear in that same cycle and hold until the next entry. After reset, pending and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the unit |
| por_req_i | input | 1 | Power-on request, sticky once seen |
| rst_req_i | input | 1 | Reset request, sticky once seen |
| nmi_req_i | input | 1 | Non-maskable request, rising-edge latched |
| irq_req_i | input | 1 | Maskable request, level |
| abort_req_i | input | 1 | Abort request, sticky once seen |
| idis_i | input | 1 | Current interrupt-disable flag |
| emu_i | input | 1 | Emulation mode bit |
| pc_i | input | 16 | Program counter to stack |
| pbank_i | input | 8 | Current program bank |
| flags_i | input | 8 | Current flag byte |
| sw_cop_i | input | 1 | Software source kind: 0 BRK, 1 COP |
| enter_i | input | 1 | Exception entry strobe |
| pending_o | output | 5 | Pending request bits |
| honour_o | output | 5 | Requests that would be honoured now |
| done_o | output | 1 | Entry results valid |
| src_o | output | 3 | Serviced source code |
| vector_o | output | 16 | Vector address |
| frame_o | output | 32 | Stack frame image, highest byte pushed first |
| frame_len_o | output | 3 | Frame length in bytes |
| pbank_o | output | 8 | Program bank after entry |
| idis_o | output | 1 | Interrupt-disable flag after entry |

## Verification
Request lines reach `pending_o` one edge after they are driven, and `honour_o` follows `pending_o` and `idis_i` in the same cycle with no further delay. Entry results and the cleared pending bit both appear one edge after the `enter_i` cycle. The bench therefore drives on the falling edge and samples just after the following rising edge. The IRQ level refill is checked one further edge after its service.

// File: rtl/exc_vu_pkg.sv
package exc_vu_pkg;
   localparam int unsigned PEND_W = 5;
   localparam int unsigned PB_POR = 0;
   localparam int unsigned PB_RST = 1;
   localparam int unsigned PB_IRQ = 2;
   localparam int unsigned PB_NMI = 3;
   localparam int unsigned PB_ABT = 4;

   typedef enum logic [2:0] {
      SRC_RESET = 3'd0,
      SRC_ABORT = 3'd1,
      SRC_NMI   = 3'd2,
      SRC_IRQ   = 3'd3,
      SRC_BRK   = 3'd4,
      SRC_COP   = 3'd5
   } src_e;
endpackage

// File: rtl/exc_vu_pending.sv
module exc_vu_pending
   import exc_vu_pkg::*;
#(
   parameter bit NMI_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_i,
   input  logic              rst_i,
   input  logic              irq_i,
   input  logic              nmi_i,
   input  logic              abort_i,
   input  logic [PEND_W-1:0] clr_i,
   output logic [PEND_W-1:0] pend_o
);
   logic nmi_set;

   generate
      if (NMI_EDGE) begin : g_nmi_edge
         logic nmi_q;
         always_ff @(posedge clk) begin
            if (!rst_n) nmi_q <= 1'b0;
            else        nmi_q <= nmi_i;
         end
         assign nmi_set = nmi_i & ~nmi_q;
      end else begin : g_nmi_level
         assign nmi_set = nmi_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_o <= '0;
      end else begin
         pend_o[PB_POR] <= (pend_o[PB_POR] & ~clr_i[PB_POR]) | por_i;
         pend_o[PB_RST] <= (pend_o[PB_RST] & ~clr_i[PB_RST]) | rst_i;
         pend_o[PB_ABT] <= (pend_o[PB_ABT] & ~clr_i[PB_ABT]) | abort_i;
         pend_o[PB_NMI] <= (pend_o[PB_NMI] & ~clr_i[PB_NMI]) | nmi_set;
         pend_o[PB_IRQ] <= irq_i & ~clr_i[PB_IRQ];
      end
   end
endmodule

// File: rtl/exc_vu_select.sv
module exc_vu_select
   import exc_vu_pkg::*;
#(
   parameter int unsigned       VEC_W      = 16,
   parameter logic [VEC_W-1:0]  V_RESET    = 16'hFFFC,
   parameter logic [VEC_W-1:0]  V_ABORT    = 16'hFFF8,
   parameter logic [VEC_W-1:0]  V_NMI      = 16'hFFFA,
   parameter logic [VEC_W-1:0]  V_IRQ      = 16'hFFFE,
   parameter logic [VEC_W-1:0]  V_BRK_EMU  = 16'hFFFE,
   parameter logic [VEC_W-1:0]  V_BRK_NAT  = 16'hFFF6,
   parameter logic [VEC_W-1:0]  V_COP      = 16'hFFF4
) (
   input  logic [PEND_W-1:0] honour_i,
   input  logic              emu_i,
   input  logic              sw_cop_i,
   output src_e              src_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic [PEND_W-1:0] clr_o
);
   always_comb begin
      clr_o = '0;
      if (honour_i[PB_POR] | honour_i[PB_RST]) begin
         src_o = SRC_RESET;
         clr_o[PB_POR] = 1'b1;
         clr_o[PB_RST] = 1'b1;
      end else if (honour_i[PB_ABT]) begin
         src_o = SRC_ABORT;
         clr_o[PB_ABT] = 1'b1;
      end else if (honour_i[PB_NMI]) begin
         src_o = SRC_NMI;
         clr_o[PB_NMI] = 1'b1;
      end else if (honour_i[PB_IRQ]) begin
         src_o = SRC_IRQ;
         clr_o[PB_IRQ] = 1'b1;
      end else begin
         src_o = sw_cop_i ? SRC_COP : SRC_BRK;
      end
   end

   always_comb begin
      unique case (src_o)
         SRC_RESET: vec_o = V_RESET;
         SRC_ABORT: vec_o = V_ABORT;
         SRC_NMI:   vec_o = V_NMI;
         SRC_IRQ:   vec_o = V_IRQ;
         SRC_BRK:   vec_o = emu_i ? V_BRK_EMU : V_BRK_NAT;
         default:   vec_o = V_COP;
      endcase
   end
endmodule

// File: rtl/exc_vu_frame.sv
module exc_vu_frame
   import exc_vu_pkg::*;
#(
   parameter int unsigned PC_W    = 16,
   parameter int unsigned BANK_W  = 8,
   parameter int unsigned FLAG_W  = 8,
   parameter int unsigned BRK_BIT = 4,
   localparam int unsigned FRAME_W = BANK_W + PC_W + FLAG_W,
   localparam int unsigned NAT_LEN = FRAME_W / 8,
   localparam int unsigned EMU_LEN = (PC_W + FLAG_W) / 8,
   localparam int unsigned LEN_W   = $clog2(NAT_LEN + 1)
) (
   input  src_e               src_i,
   input  logic               emu_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [BANK_W-1:0]  pbank_i,
   input  logic [FLAG_W-1:0]  flags_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic [LEN_W-1:0]   len_o,
   output logic [BANK_W-1:0]  pbank_o
);
   logic [FLAG_W-1:0] emu_flags;

   always_comb begin
      emu_flags          = flags_i;
      emu_flags[BRK_BIT] = (src_i == SRC_BRK);
   end

   always_comb begin
      if (emu_i) begin
         frame_o = {{BANK_W{1'b0}}, pc_i, emu_flags};
         len_o   = LEN_W'(EMU_LEN);
         pbank_o = pbank_i;
      end else begin
         frame_o = {pbank_i, pc_i, flags_i};
         len_o   = LEN_W'(NAT_LEN);
         pbank_o = '0;
      end
   end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
   import exc_vu_pkg::*;
#(
   parameter int unsigned PC_W     = 16,
   parameter int unsigned BANK_W   = 8,
   parameter int unsigned FLAG_W   = 8,
   parameter int unsigned BRK_BIT  = 4,
   parameter bit          NMI_EDGE = 1'b1,
   localparam int unsigned FRAME_W = BANK_W + PC_W + FLAG_W,
   localparam int unsigned LEN_W   = $clog2(FRAME_W / 8 + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               por_req_i,
   input  logic               rst_req_i,
   input  logic               nmi_req_i,
   input  logic               irq_req_i,
   input  logic               abort_req_i,
   input  logic               idis_i,
   input  logic               emu_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [BANK_W-1:0]  pbank_i,
   input  logic [FLAG_W-1:0]  flags_i,
   input  logic               sw_cop_i,
   input  logic               enter_i,
   output logic [PEND_W-1:0]  pending_o,
   output logic [PEND_W-1:0]  honour_o,
   output logic               done_o,
   output logic [2:0]         src_o,
   output logic [PC_W-1:0]    vector_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic [LEN_W-1:0]   frame_len_o,
   output logic [BANK_W-1:0]  pbank_o,
   output logic               idis_o
);
   generate
      if ((PC_W % 8) != 0 || (BANK_W % 8) != 0 || (FLAG_W % 8) != 0) begin : g_bad_width
         $error("exc_vector_unit: register widths must be whole bytes");
      end
      if (BRK_BIT >= FLAG_W) begin : g_bad_brk
         $error("exc_vector_unit: BRK_BIT outside flag byte");
      end
   endgenerate

   logic [PEND_W-1:0]  clr_sel, clr_app;
   src_e               sel_src;
   logic [PC_W-1:0]    sel_vec;
   logic [FRAME_W-1:0] sel_frame;
   logic [LEN_W-1:0]   sel_len;
   logic [BANK_W-1:0]  sel_pbank;

   assign clr_app = enter_i ? clr_sel : '0;

   exc_vu_pending #(.NMI_EDGE(NMI_EDGE)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .por_i   (por_req_i),
      .rst_i   (rst_req_i),
      .irq_i   (irq_req_i),
      .nmi_i   (nmi_req_i),
      .abort_i (abort_req_i),
      .clr_i   (clr_app),
      .pend_o  (pending_o)
   );

   always_comb begin
      honour_o         = pending_o;
      honour_o[PB_IRQ] = pending_o[PB_IRQ] & ~idis_i;
   end

   exc_vu_select #(.VEC_W(PC_W)) u_sel (
      .honour_i (honour_o),
      .emu_i    (emu_i),
      .sw_cop_i (sw_cop_i),
      .src_o    (sel_src),
      .vec_o    (sel_vec),
      .clr_o    (clr_sel)
   );

   exc_vu_frame #(
      .PC_W    (PC_W),
      .BANK_W  (BANK_W),
      .FLAG_W  (FLAG_W),
      .BRK_BIT (BRK_BIT)
   ) u_frame (
      .src_i   (sel_src),
      .emu_i   (emu_i),
      .pc_i    (pc_i),
      .pbank_i (pbank_i),
      .flags_i (flags_i),
      .frame_o (sel_frame),
      .len_o   (sel_len),
      .pbank_o (sel_pbank)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         src_o       <= '0;
         vector_o    <= '0;
         frame_o     <= '0;
         frame_len_o <= '0;
         pbank_o     <= '0;
         idis_o      <= 1'b0;
      end else begin
         done_o <= enter_i;
         if (enter_i) begin
            src_o       <= sel_src;
            vector_o    <= sel_vec;
            frame_o     <= sel_frame;
            frame_len_o <= sel_len;
            pbank_o     <= sel_pbank;
            idis_o      <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/exc_vu_checker.sv
module exc_vu_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        nmi_req_i,
   input logic        idis_i,
   input logic        enter_i,
   input logic [4:0]  pending_o,
   input logic [4:0]  honour_o,
   input logic        done_o,
   input logic [15:0] vector_o,
   input logic [2:0]  frame_len_o,
   input logic [7:0]  pbank_o,
   input logic        idis_o
);
   p_done_follows_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> done_o);

   p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enter_i |=> $stable(vector_o) && !done_o);

   p_idis_after_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> idis_o);

   p_native_bank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && frame_len_o == 3'd4) |-> pbank_o == 8'h00);

   p_frame_len_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (frame_len_o == 3'd3 || frame_len_o == 3'd4));

   p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idis_i |-> !honour_o[2]);

   p_nmi_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_i && honour_o[3] && !honour_o[0] && !honour_o[1] && !honour_o[4] && !nmi_req_i)
      |=> !pending_o[3]);
endmodule

bind exc_vector_unit exc_vu_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .nmi_req_i   (nmi_req_i),
   .idis_i      (idis_i),
   .enter_i     (enter_i),
   .pending_o   (pending_o),
   .honour_o    (honour_o),
   .done_o      (done_o),
   .vector_o    (vector_o),
   .frame_len_o (frame_len_o),
   .pbank_o     (pbank_o),
   .idis_o      (idis_o)
);

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por_req_i = 0, rst_req_i = 0, nmi_req_i = 0, irq_req_i = 0, abort_req_i = 0;
   logic idis_i = 0, emu_i = 1, sw_cop_i = 0, enter_i = 0;
   logic [15:0] pc_i = '0;
   logic [7:0]  pbank_i = '0, flags_i = '0;
   logic [4:0]  pending_o, honour_o;
   logic        done_o, idis_o;
   logic [2:0]  src_o, frame_len_o;
   logic [15:0] vector_o;
   logic [31:0] frame_o;
   logic [7:0]  pbank_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   exc_vector_unit uut (
      .clk(clk), .rst_n(rst_n), .por_req_i(por_req_i), .rst_req_i(rst_req_i),
      .nmi_req_i(nmi_req_i), .irq_req_i(irq_req_i), .abort_req_i(abort_req_i),
      .idis_i(idis_i), .emu_i(emu_i), .pc_i(pc_i), .pbank_i(pbank_i),
      .flags_i(flags_i), .sw_cop_i(sw_cop_i), .enter_i(enter_i),
      .pending_o(pending_o), .honour_o(honour_o), .done_o(done_o),
      .src_o(src_o), .vector_o(vector_o), .frame_o(frame_o),
      .frame_len_o(frame_len_o), .pbank_o(pbank_o), .idis_o(idis_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_enter(input logic cop);
      @(negedge clk);
      sw_cop_i = cop;
      enter_i  = 1'b1;
      @(posedge clk); #1;
      enter_i  = 1'b0;
      chk("R10 done after enter", {31'd0, done_o}, 32'd1);
   endtask

   task automatic t_reset_state();
      chk("R10 reset pending", {27'd0, pending_o}, 32'd0);
      chk("R10 reset done", {31'd0, done_o}, 32'd0);
   endtask

   task automatic t_priority();
      @(negedge clk);
      emu_i = 1; idis_i = 0; pc_i = 16'h4000; flags_i = 8'h30; pbank_i = 8'h00;
      rst_req_i = 1; abort_req_i = 1; nmi_req_i = 1; irq_req_i = 1;
      tick();
      chk("R2 pending encoding", {27'd0, pending_o}, 32'h1E);
      chk("R9 honour unmasked", {27'd0, honour_o}, 32'h1E);
      @(negedge clk);
      rst_req_i = 0; abort_req_i = 0;
      do_enter(0);
      chk("R1 reset wins", {29'd0, src_o}, 32'd0);
      chk("R5 reset vector", {16'd0, vector_o}, 32'hFFFC);
      chk("R6 hw emu frame", frame_o, 32'h0040_0020);
      chk("R6 emu length", {29'd0, frame_len_o}, 32'd3);
      chk("R2 reset cleared", {27'd0, pending_o}, 32'h1C);
      do_enter(0);
      chk("R1 abort next", {29'd0, src_o}, 32'd1);
      chk("R5 abort vector", {16'd0, vector_o}, 32'hFFF8);
      chk("R2 abort cleared", {27'd0, pending_o}, 32'h0C);
      do_enter(0);
      chk("R1 nmi next", {29'd0, src_o}, 32'd2);
      chk("R5 nmi vector", {16'd0, vector_o}, 32'hFFFA);
      chk("R2 nmi cleared", {27'd0, pending_o}, 32'h04);
      do_enter(0);
      chk("R1 irq next", {29'd0, src_o}, 32'd3);
      chk("R4 irq vector", {16'd0, vector_o}, 32'hFFFE);
      chk("R4 irq cleared at service", {27'd0, pending_o}, 32'h00);
      tick();
      chk("R4 irq level refills", {27'd0, pending_o}, 32'h04);
      chk("R10 done low without enter", {31'd0, done_o}, 32'd0);
      chk("R10 results hold", {16'd0, vector_o}, 32'hFFFE);
      @(negedge clk);
      irq_req_i = 0;
      tick();
      chk("R4 irq follows low level", {27'd0, pending_o}, 32'h00);
   endtask

   task automatic t_nmi_edge();
      tick(); tick(); tick();
      chk("R3 held nmi not repended", {31'd0, pending_o[3]}, 32'd0);
      @(negedge clk); nmi_req_i = 0;
      @(negedge clk); nmi_req_i = 1;
      tick();
      chk("R3 new edge pends", {31'd0, pending_o[3]}, 32'd1);
      @(negedge clk); nmi_req_i = 0;
      do_enter(0);
      chk("R3 nmi serviced", {29'd0, src_o}, 32'd2);
   endtask

   task automatic t_irq_mask_brk_emu();
      @(negedge clk);
      idis_i = 1; irq_req_i = 1; emu_i = 1;
      pc_i = 16'h1234; flags_i = 8'h20; pbank_i = 8'h7E;
      tick();
      chk("R9 irq pending while masked", {31'd0, pending_o[2]}, 32'd1);
      chk("R9 irq not honoured", {31'd0, honour_o[2]}, 32'd0);
      do_enter(0);
      chk("R1 masked irq yields brk", {29'd0, src_o}, 32'd4);
      chk("R5 brk emu vector", {16'd0, vector_o}, 32'hFFFE);
      chk("R6 brk emu frame", frame_o, 32'h0012_3430);
      chk("R7 emu bank kept", {24'd0, pbank_o}, 32'h7E);
      chk("R8 idis set", {31'd0, idis_o}, 32'd1);
      chk("R2 software clears nothing", {31'd0, pending_o[2]}, 32'd1);
      @(negedge clk); irq_req_i = 0;
   endtask

   task automatic t_native();
      @(negedge clk);
      emu_i = 0; idis_i = 0; pc_i = 16'hBEEF; pbank_i = 8'h12; flags_i = 8'h05;
      tick();
      do_enter(0);
      chk("R5 brk native vector", {16'd0, vector_o}, 32'hFFF6);
      chk("R7 native frame", frame_o, 32'h12BE_EF05);
      chk("R7 native length", {29'd0, frame_len_o}, 32'd4);
      chk("R7 native bank zero", {24'd0, pbank_o}, 32'h00);
      chk("R8 idis set native", {31'd0, idis_o}, 32'd1);
      do_enter(1);
      chk("R1 cop source", {29'd0, src_o}, 32'd5);
      chk("R5 cop vector", {16'd0, vector_o}, 32'hFFF4);
      @(negedge clk);
      emu_i = 1; flags_i = 8'h35;
      do_enter(1);
      chk("R6 cop emu break clear", frame_o, 32'h00BE_EF25);
      chk("R7 emu bank passes", {24'd0, pbank_o}, 32'h12);
   endtask

   task automatic t_power_on();
      @(negedge clk); por_req_i = 1;
      @(negedge clk); por_req_i = 0;
      chk("R2 power-on bit0", {27'd0, pending_o}, 32'h01);
      do_enter(0);
      chk("R1 power-on is reset", {29'd0, src_o}, 32'd0);
      chk("R5 power-on vector", {16'd0, vector_o}, 32'hFFFC);
      chk("R2 power-on cleared", {27'd0, pending_o}, 32'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset_state();
      @(negedge clk); rst_n = 1'b1;
      tick();
      t_reset_state();
      t_priority();
      t_nmi_edge();
      t_irq_mask_brk_emu();
      t_native();
      t_power_on();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule